// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles, producing one quotient bit per cycle with the classic restoring long-division scheme. A request carries a dividend, a divisor and a flag choosing signed or unsigned arithmetic. The result carries a quotient, which is the low word of the result pair, a remainder, which is the high word, and a flag that reports a zero divisor.

Internally the divisor magnitude is parked in the upper half of a double-width register and slides one place right after each step. The zero-extended dividend magnitude sits in a double-width remainder register. At every step a trial difference is formed. When the trial goes negative the old remainder is kept, which restores it, and a 0 enters the quotient. When it does not go negative the difference is kept and a 1 enters. Signed requests are divided as magnitudes, and the signs are applied to the result afterwards.

Requests arrive on a valid/ready pair. `in_ready` is high only while the divider is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Results leave on a second valid/ready pair. `out_valid` and every result pin hold steady for as long as `out_ready` stays low. That back-pressure stops the divider from taking the next request, because it becomes idle again only after the result is taken.

Top module: `rdiv_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0. Asserting `rst` during a division abandons it.
- R2: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until the result is taken, `in_ready` is 0. The operand pins and `in_valid` are ignored in that interval, so changing them has no effect on the result.
- R3: With `in_signed` = 0 and a nonzero divisor, `out_quotient` is the floor of dividend/divisor and `out_remainder` is dividend minus quotient times divisor, both unsigned N-bit values.
- R4: For a nonzero divisor, `out_valid` rises on the edge that is N+1 edges after the accepting edge, one edge for each restoring step.
- R5: With `in_signed` = 1, both operands are two's complement. The quotient is the magnitude quotient, negated when the operand signs differ. The remainder has the magnitude remainder's size and takes the sign of the dividend. Results wrap to N bits, so the most negative value divided by -1 gives the most negative value with remainder 0.
- R6: A zero divisor sets `out_div_zero` to 1. In that case the quotient is all ones, the remainder equals the dividend pin value as given, and `out_valid` rises on the accepting edge itself.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_quotient`, `out_remainder` and `out_div_zero` keep their values. A result is taken on an edge where `out_valid` and `out_ready` are both 1. After that edge `out_valid` is 0 and `in_ready` is 1.
- R8: For a nonzero divisor `out_div_zero` is 0, in both signed and unsigned mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Divider idle and able to take a request |
| in_dividend | input | N | Dividend |
| in_divisor | input | N | Divisor |
| in_signed | input | 1 | 1: two's complement operands; 0: unsigned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | N | Quotient (low word of the result pair) |
| out_remainder | output | N | Remainder (high word of the result pair) |
| out_div_zero | output | 1 | Divisor was zero |

## Verification
A request with a nonzero divisor has its result due N+1 edges after the accepting edge. A request with a zero divisor has its result due at the accepting edge itself. After each accepting edge the bench counts falling edges until `out_valid` is seen. It compares that count with N+1 or with 0, and only then reads the result pins, so every value comparison happens in the cycle the result first appears. For back-pressure, the bench withholds `out_ready` and re-reads the held result on several later falling edges. It then expects `out_valid` low and `in_ready` high one edge after the result is taken.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  // Controller phases of the divider
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_prep.sv
// Operand conditioning: magnitudes, result sign decisions, zero detect.
module rdiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  output logic [W-1:0] mag_dividend,
  output logic [W-1:0] mag_divisor,
  output logic         flip_quo,
  output logic         flip_rem,
  output logic         zero_div
);
  logic a_neg, b_neg;

  always_comb begin
    a_neg        = is_signed & dividend[W-1];
    b_neg        = is_signed & divisor[W-1];
    mag_dividend = a_neg ? (~dividend + 1'b1) : dividend;
    mag_divisor  = b_neg ? (~divisor + 1'b1) : divisor;
    flip_quo     = a_neg ^ b_neg;
    flip_rem     = a_neg;
    zero_div     = (divisor == '0);
  end
endmodule

// File: rtl/rdiv_step.sv
// One restoring step: trial subtract, keep or restore, shift quotient and divisor.
module rdiv_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_cur,
  input  logic [2*W-1:0] dvs_cur,
  input  logic [W-1:0]   quo_cur,
  output logic [2*W-1:0] rem_nxt,
  output logic [2*W-1:0] dvs_nxt,
  output logic [W-1:0]   quo_nxt
);
  localparam int DW = 2 * W;

  logic [DW:0] trial;
  logic        below;

  always_comb begin
    trial   = {1'b0, rem_cur} - {1'b0, dvs_cur};
    below   = trial[DW];
    // A negative trial leaves the old remainder in place (the restore)
    rem_nxt = below ? rem_cur : trial[DW-1:0];
    quo_nxt = {quo_cur[W-2:0], ~below};
    dvs_nxt = {1'b0, dvs_cur[DW-1:1]};
  end
endmodule

// File: rtl/rdiv_fix.sv
// Applies the result signs to the magnitude quotient and remainder.
module rdiv_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         flip_quo,
  input  logic         flip_rem,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out
);
  always_comb begin
    quo_out = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
    rem_out = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  input  logic         in_signed,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic         out_div_zero
);
  localparam int DW    = 2 * W;
  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  rdiv_state_e   st_q;
  logic [DW-1:0] rem_q, dvs_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic          fq_q, fr_q, dz_q;

  logic [W-1:0]  mag_a, mag_b;
  logic          flip_q, flip_r, zero_b;
  logic [DW-1:0] rem_n, dvs_n;
  logic [W-1:0]  quo_n;

  rdiv_prep #(.W(W)) u_prep (
    .dividend     (in_dividend),
    .divisor      (in_divisor),
    .is_signed    (in_signed),
    .mag_dividend (mag_a),
    .mag_divisor  (mag_b),
    .flip_quo     (flip_q),
    .flip_rem     (flip_r),
    .zero_div     (zero_b)
  );

  rdiv_step #(.W(W)) u_step (
    .rem_cur (rem_q),
    .dvs_cur (dvs_q),
    .quo_cur (quo_q),
    .rem_nxt (rem_n),
    .dvs_nxt (dvs_n),
    .quo_nxt (quo_n)
  );

  rdiv_fix #(.W(W)) u_fix (
    .quo_mag  (quo_q),
    .rem_mag  (rem_q[W-1:0]),
    .flip_quo (fq_q),
    .flip_rem (fr_q),
    .quo_out  (out_quotient),
    .rem_out  (out_remainder)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      fq_q  <= 1'b0;
      fr_q  <= 1'b0;
      dz_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            cnt_q <= '0;
            if (zero_b) begin
              // Zero divisor: finish at once, dividend passes through as remainder
              st_q  <= ST_DONE;
              rem_q <= {{W{1'b0}}, in_dividend};
              quo_q <= '1;
              fq_q  <= 1'b0;
              fr_q  <= 1'b0;
              dz_q  <= 1'b1;
            end else begin
              st_q  <= ST_RUN;
              rem_q <= {{W{1'b0}}, mag_a};
              dvs_q <= {mag_b, {W{1'b0}}};
              quo_q <= '0;
              fq_q  <= flip_q;
              fr_q  <= flip_r;
              dz_q  <= 1'b0;
            end
          end
        end
        ST_RUN: begin
          rem_q <= rem_n;
          dvs_q <= dvs_n;
          quo_q <= quo_n;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_DONE;
        end
        ST_DONE: begin
          if (out_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready     = (st_q == ST_IDLE);
  assign out_valid    = (st_q == ST_DONE);
  assign out_div_zero = dz_q;
endmodule

// File: rtl/rdiv_chk.sv
module rdiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_divisor,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_quotient,
  input logic [W-1:0] out_remainder,
  input logic         out_div_zero
);
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] SAT = CW'(W + 2);

  logic          take;
  logic [CW-1:0] since_q;

  assign take = in_valid && in_ready;

  // Edges elapsed since the last accepted request, saturating
  always_ff @(posedge clk) begin
    if (rst) since_q <= SAT;
    else if (take) since_q <= '0;
    else if (since_q != SAT) since_q <= since_q + 1'b1;
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready); // R2

  AST_NO_TAKE_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R2

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_div_zero ? (since_q == '0) : (since_q == CW'(W + 1)))); // R4

  AST_ZERO_DIV_FAST: assert property (@(posedge clk) disable iff (rst)
    (take && (in_divisor == '0)) |=> (out_valid && out_div_zero)); // R6

  AST_ZERO_DIV_QUO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_div_zero) |-> (out_quotient == '1)); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) &&
      $stable(out_remainder) && $stable(out_div_zero))); // R7

  AST_RESULT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R7
endmodule

bind rdiv_top rdiv_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_divisor    (in_divisor),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder),
  .out_div_zero  (out_div_zero)
);

// File: tb/tb_rdiv_top.sv
module tb_rdiv_top;
  localparam int W = 32;

  typedef struct packed {
    logic        sgn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] q;
    logic [31:0] r;
    logic        z;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd74,         32'd8,          32'd9,          32'd2,          1'b0}, // R3
    '{1'b0, 32'd100,        32'd7,          32'd14,         32'd2,          1'b0}, // R3
    '{1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0,          1'b0}, // R3
    '{1'b0, 32'd5,          32'd9,          32'd0,          32'd5,          1'b0}, // R3
    '{1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0,          1'b0}, // R3
    '{1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0,          32'h80000000,   1'b0}, // R3
    '{1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF,   1'b0}, // R5 -7/2
    '{1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1,          1'b0}, // R5 7/-2
    '{1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF,   1'b0}, // R5 -7/-2
    '{1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0,          1'b0}, // R5 wrap
    '{1'b1, 32'h80000000,   32'd2,          32'hC0000000,   32'd0,          1'b0}, // R5
    '{1'b0, 32'd1234,       32'd0,          32'hFFFFFFFF,   32'd1234,       1'b1}, // R6
    '{1'b1, 32'hFFFFFFFB,   32'd0,          32'hFFFFFFFF,   32'hFFFFFFFB,   1'b1}  // R6
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_dividend;
  logic [W-1:0] in_divisor;
  logic         in_signed;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_quotient;
  logic [W-1:0] out_remainder;
  logic         out_div_zero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rdiv_top #(.W(W)) dut (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_dividend   (in_dividend),
    .in_divisor    (in_divisor),
    .in_signed     (in_signed),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_quotient  (out_quotient),
    .out_remainder (out_remainder),
    .out_div_zero  (out_div_zero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request, count edges to the result, compare, then consume it.
  task automatic run_one(input vec_t v, input string tag, input bit hold_back);
    int lat;
    @(negedge clk);
    chk({tag, " R2 in_ready idle"}, 32'(in_ready), 32'd1);
    in_signed   = v.sgn;
    in_dividend = v.a;
    in_divisor  = v.b;
    in_valid    = 1'b1;
    out_ready   = !hold_back;
    @(posedge clk);
    @(negedge clk);
    // Disturb the operand pins while busy: must have no effect (R2)
    in_dividend = ~v.a;
    in_divisor  = v.b ^ 32'h5A5A0001;
    in_signed   = ~v.sgn;
    lat = 0;
    while (!out_valid && lat < 200) begin
      chk({tag, " R2 busy"}, 32'(in_ready), 32'd0);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk({tag, " R4/R6 latency"}, 32'(lat), v.z ? 32'd0 : 32'(W + 1));
    chk({tag, " R3/R5 quotient"}, out_quotient, v.q);
    chk({tag, " R3/R5 remainder"}, out_remainder, v.r);
    chk({tag, " R6/R8 div_zero"}, 32'(out_div_zero), 32'(v.z));
    if (hold_back) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk({tag, " R7 hold valid"}, 32'(out_valid), 32'd1);
        chk({tag, " R7 hold quotient"}, out_quotient, v.q);
        chk({tag, " R7 hold remainder"}, out_remainder, v.r);
        chk({tag, " R7 no accept"}, 32'(in_ready), 32'd0);
      end
      out_ready = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R7 released"}, 32'(out_valid), 32'd0);
    chk({tag, " R7 idle again"}, 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst         = 1'b1;
    in_valid    = 1'b0;
    in_dividend = '0;
    in_divisor  = '0;
    in_signed   = 1'b0;
    out_ready   = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset in_ready", 32'(in_ready), 32'd1);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset in_ready", 32'(in_ready), 32'd1);
    chk("R1 after reset out_valid", 32'(out_valid), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_one(VECS[i], $sformatf("vec%0d", i), 1'b0);
    end

    // Back-pressure on a regular and on a zero-divisor result (R7)
    run_one(VECS[1], "bp_div", 1'b1);
    run_one(VECS[11], "bp_zero", 1'b1);

    // Reset in the middle of a division abandons it (R1)
    @(negedge clk);
    in_dividend = 32'd999;
    in_divisor  = 32'd3;
    in_signed   = 1'b0;
    in_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 abort in_ready", 32'(in_ready), 32'd1);
    chk("R1 abort out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    repeat (W + 4) begin
      @(negedge clk);
      chk("R1 abandoned stays idle", 32'(out_valid), 32'd0);
    end

    // Fresh work after the abort still divides correctly (R3)
    run_one('{1'b0, 32'd999, 32'd3, 32'd333, 32'd0, 1'b0}, "post_abort", 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule